// File: doc/BRIEF.md
# Linearized Phase-Frequency Detector with Lock Flag

This block compares two divided pulse trains on a fast system clock. One is a reference train and the other a variable train from the loop divider. Each arrives as a one-cycle edge event: `ref_edge` or `var_edge`. The block opens an error interval at whichever edge comes first and closes it at the other.

While the variable train leads (it is higher in frequency or earlier in phase), the variable-side error line `phi_v_n` is held low. While it lags, the reference-side line `phi_r_n` is held low. When both edges arrive in the same cycle, both lines go low together for a fixed minimum width of `MIN_PULSE` cycles. This coincident pulse removes the dead zone around lock.

A combined single-line error output is provided as a data bit plus an output enable, for use by a three-state driver. A lock flag drops only while one side alone is in error.

The edges are events, not a data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal. Every output is registered and reflects an edge two clock edges after the edge is presented: the first edge updates the internal state and the second updates the output register.

Top module: `pfd_lin_detector`

## Requirements
- R1: After reset, and with no edge pending, `phi_v_n`=1, `phi_r_n`=1, `pd_oe`=0, `pd_data`=0 and `lock`=1.
- R2: A `var_edge` alone, with nothing pending, drives `phi_v_n` low two cycles later. It stays low until the next `ref_edge` and returns high two cycles after that edge. `phi_r_n` stays high throughout.
- R3: A `ref_edge` alone, with nothing pending, drives `phi_r_n` low in the same way. It stays low until the next `var_edge`, and `phi_v_n` stays high throughout.
- R4: `ref_edge` and `var_edge` together, with nothing pending, drive both error lines low for exactly `MIN_PULSE` consecutive cycles (default 2). The window starts two cycles after the edges.
- R5: Any edge presented in the `MIN_PULSE` cycles that follow a coincident pair is ignored. After that pulse the outputs return to the R1 values.
- R6: The combined output is enabled (`pd_oe`=1) only while exactly one side is in error. It then drives `pd_data`=0 while the variable side leads and `pd_data`=1 while it lags. Otherwise `pd_oe`=0 and `pd_data`=0.
- R7: `lock` is 0 exactly while one error line alone is low. It stays 1 during a coincident pulse.
- R8: While one side leads, further edges of the leading side are ignored. An edge pair arriving in one cycle closes the open interval and opens a new one on the same side, so the error line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-cycle event: reference train edge |
| var_edge | input | 1 | One-cycle event: variable train edge |
| phi_v_n | output | 1 | Active-low error line, variable side leads |
| phi_r_n | output | 1 | Active-low error line, variable side lags |
| pd_data | output | 1 | Data bit of the combined three-state error output |
| pd_oe | output | 1 | Output enable of the combined error output |
| lock | output | 1 | High while locked, low while one side alone is in error |

## Verification
On every cycle, the assertions check several properties of the state machine:
- how an open interval holds or closes;
- that a coincident pair enters the pulse state;
- that the pulse state ignores edges until its timer expires;
- that both lines are never low together for more than `MIN_PULSE` cycles;
- that the combined output and the lock flag agree with the two error lines.

Only the bench's scenarios can show the end-to-end timing. That covers the two-cycle latency from an edge to the output, the exact pulse width, and the recovery to the idle values after ignored edges. It also covers how long lead and lag intervals are held under random edge patterns, which the bench compares each cycle against its own model.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Detector state: which side, if any, currently holds an open error interval.
  typedef enum logic [1:0] {
    PD_IDLE  = 2'd0,
    PD_VLEAD = 2'd1,
    PD_RLEAD = 2'd2,
    PD_COINC = 2'd3
  } pd_state_e;

endpackage

// File: rtl/pfd_pulse_timer.sv
module pfd_pulse_timer #(
  parameter int MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic last_o
);
  localparam int CW = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;
  localparam logic [CW-1:0] LOAD = CW'(MIN_PULSE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= LOAD;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == '0);

  // R4: once running, the count only moves downward, by one per cycle.
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i && !last_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pfd_phase_fsm.sv
module pfd_phase_fsm
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_edge_i,
  input  logic      var_edge_i,
  input  logic      timer_last_i,
  output pd_state_e state_o,
  output logic      coinc_start_o
);
  pd_state_e state_q, state_d;

  always_comb begin
    state_d       = state_q;
    coinc_start_o = 1'b0;
    unique case (state_q)
      PD_IDLE: begin
        if (ref_edge_i && var_edge_i) begin
          state_d       = PD_COINC;
          coinc_start_o = 1'b1;
        end else if (var_edge_i) begin
          state_d = PD_VLEAD;
        end else if (ref_edge_i) begin
          state_d = PD_RLEAD;
        end
      end
      PD_VLEAD: begin
        // The reference edge closes the interval; a variable edge in the same cycle reopens it.
        if (ref_edge_i) state_d = var_edge_i ? PD_VLEAD : PD_IDLE;
      end
      PD_RLEAD: begin
        if (var_edge_i) state_d = ref_edge_i ? PD_RLEAD : PD_IDLE;
      end
      PD_COINC: begin
        // Edges are ignored until the minimum pulse has elapsed.
        if (timer_last_i) state_d = PD_IDLE;
      end
      default: state_d = PD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PD_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R2: a leading variable interval stays open until a reference edge arrives.
  p_vlead_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_VLEAD && !ref_edge_i) |=> (state_q == PD_VLEAD));
  // R2: a reference edge alone closes a leading variable interval.
  p_vlead_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_VLEAD && ref_edge_i && !var_edge_i) |=> (state_q == PD_IDLE));
  // R3: a lagging interval stays open until a variable edge arrives.
  p_rlead_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_RLEAD && !var_edge_i) |=> (state_q == PD_RLEAD));
  // R4: a coincident pair from idle enters the pulse state.
  p_coinc_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_IDLE && ref_edge_i && var_edge_i) |=> (state_q == PD_COINC));
  // R5: the pulse state is left only through the timer, whatever the edges do.
  p_coinc_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_COINC && !timer_last_i) |=> (state_q == PD_COINC));
  // R8: an edge pair during a lead keeps the same side leading.
  p_reopen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_RLEAD && ref_edge_i && var_edge_i) |=> (state_q == PD_RLEAD));

endmodule

// File: rtl/pfd_drive_stage.sv
module pfd_drive_stage
  import pfd_pkg::*;
#(
  parameter int MIN_PULSE = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pd_state_e state_i,
  output logic      phi_v_n_o,
  output logic      phi_r_n_o,
  output logic      pd_data_o,
  output logic      pd_oe_o,
  output logic      lock_o
);
  logic v_err, r_err;

  assign v_err = (state_i == PD_VLEAD) || (state_i == PD_COINC);
  assign r_err = (state_i == PD_RLEAD) || (state_i == PD_COINC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phi_v_n_o <= 1'b1;
      phi_r_n_o <= 1'b1;
      pd_data_o <= 1'b0;
      pd_oe_o   <= 1'b0;
      lock_o    <= 1'b1;
    end else begin
      phi_v_n_o <= !v_err;
      phi_r_n_o <= !r_err;
      pd_data_o <= (state_i == PD_RLEAD);
      pd_oe_o   <= v_err ^ r_err;
      lock_o    <= !(v_err ^ r_err);
    end
  end

  // Checker: consecutive cycles with both error lines low.
  localparam int BW = $clog2(MIN_PULSE + 2);
  logic [BW-1:0] both_cnt_q;
  logic          both_low;
  assign both_low = !phi_v_n_o && !phi_r_n_o;

  always_ff @(posedge clk) begin
    if (!rst_n)                          both_cnt_q <= '0;
    else if (!both_low)                  both_cnt_q <= '0;
    else if (both_cnt_q != BW'(MIN_PULSE)) both_cnt_q <= both_cnt_q + 1'b1;
  end

  // R4: the coincident pulse never lasts beyond its minimum width.
  p_coinc_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    both_low |-> (both_cnt_q < BW'(MIN_PULSE)));
  // R6: when enabled, the combined output follows the lag/lead direction.
  p_tri_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pd_oe_o |-> (pd_data_o == phi_v_n_o) && (phi_v_n_o != phi_r_n_o));
  // R6: a disabled combined output carries a zero data bit.
  p_tri_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_oe_o |-> !pd_data_o);
  // R7: the lock flag drops only while exactly one side is in error.
  p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |-> (phi_v_n_o ^ phi_r_n_o));

endmodule

// File: rtl/pfd_lin_detector.sv
module pfd_lin_detector
  import pfd_pkg::*;
#(
  parameter int MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  input  logic var_edge,
  output logic phi_v_n,
  output logic phi_r_n,
  output logic pd_data,
  output logic pd_oe,
  output logic lock
);
  pd_state_e state;
  logic      coinc_start;
  logic      timer_last;

  pfd_phase_fsm i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_edge_i   (ref_edge),
    .var_edge_i   (var_edge),
    .timer_last_i (timer_last),
    .state_o      (state),
    .coinc_start_o(coinc_start)
  );

  pfd_pulse_timer #(.MIN_PULSE(MIN_PULSE)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(coinc_start),
    .run_i  (state == PD_COINC),
    .last_o (timer_last)
  );

  pfd_drive_stage #(.MIN_PULSE(MIN_PULSE)) i_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_i  (state),
    .phi_v_n_o(phi_v_n),
    .phi_r_n_o(phi_r_n),
    .pd_data_o(pd_data),
    .pd_oe_o  (pd_oe),
    .lock_o   (lock)
  );

endmodule

// File: tb/test_pfd_lin_detector.sv
module test_pfd_lin_detector;
  localparam int MINP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_edge = 1'b0;
  logic var_edge = 1'b0;
  logic phi_v_n, phi_r_n, pd_data, pd_oe, lock;

  pfd_lin_detector #(.MIN_PULSE(MINP)) i_pfd_lin_detector (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .var_edge(var_edge),
    .phi_v_n(phi_v_n), .phi_r_n(phi_r_n), .pd_data(pd_data), .pd_oe(pd_oe), .lock(lock)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  string ctx = "";

  // Model: mv = variable side leading, mr = lagging, mh = remaining coincident cycles.
  bit mv = 0, mr = 0; int mh = 0;
  bit pv = 0, pr = 0; int ph = 0;

  function automatic void chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endfunction

  task automatic step(bit r, bit v);
    string t;
    @(negedge clk);
    t = (ctx != "") ? ctx : ((ph > 0) ? "R4" : (pv ? "R2" : (pr ? "R3" : "R1")));
    chk(t, "phi_v_n", int'(phi_v_n), int'(!(pv || ph > 0)));
    chk(t, "phi_r_n", int'(phi_r_n), int'(!(pr || ph > 0)));
    chk("R6", "pd_oe", int'(pd_oe), int'(pv || pr));
    chk("R6", "pd_data", int'(pd_data), int'(pr));
    chk("R7", "lock", int'(lock), int'(!(pv || pr)));
    ref_edge = r;
    var_edge = v;
    pv = mv; pr = mr; ph = mh;
    if (mh > 0) begin
      mh = mh - 1;
    end else if (mv) begin
      if (r) mv = v;
    end else if (mr) begin
      if (v) mr = r;
    end else if (r && v) begin
      mh = MINP;
    end else begin
      mv = v;
      mr = r;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "phi_v_n", int'(phi_v_n), 1);
    chk("R1", "phi_r_n", int'(phi_r_n), 1);
    chk("R1", "pd_oe", int'(pd_oe), 0);
    chk("R1", "pd_data", int'(pd_data), 0);
    chk("R1", "lock", int'(lock), 1);
    rst_n = 1'b1;
    idle(3);

    ctx = "R2"; step(0, 1); idle(4); step(1, 0); idle(3);
    ctx = "R3"; step(1, 0); idle(5); step(0, 1); idle(3);
    ctx = "R4"; step(1, 1); idle(4);
    ctx = "R5"; step(1, 1); step(1, 0); step(0, 1); idle(4);
    ctx = "R5"; step(1, 1); step(1, 1); step(1, 1); idle(4);
    ctx = "R8"; step(0, 1); step(0, 1); idle(1); step(1, 1); idle(2); step(1, 0); idle(3);
    ctx = "R8"; step(1, 0); step(1, 0); step(1, 1); idle(1); step(0, 1); idle(3);
    ctx = "";

    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom % 3;
      if (sel == 0) step(($urandom % 6) == 0, ($urandom % 6) == 0);
      else if (sel == 1) step(($urandom % 4) == 0, ($urandom % 9) == 0);
      else step(($urandom % 9) == 0, ($urandom % 4) == 0);
    end
    idle(6);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule